// File: doc/BRIEF.md
# Host Command Parser and Bus Master

This block sits behind a serial link from a host computer. It takes a stream of bytes and groups them into fixed five-byte commands. Each command is an opcode byte followed by a 32-bit payload. The commands let the host do four things:

- set the block's configuration and its bus address;
- start a burst of 32-bit bus reads whose results land in a receive FIFO;
- issue single 32-bit bus writes;
- pull words back out of the receive FIFO as bytes on a return stream.

A configuration bit hands the bus to the host. While it is set, the block also asserts a flag that disables the console-side interface. While that bit is clear, the block stays off the bus: reads produce zero words and writes are thrown away. The FIFO storage and any clock-domain crossing sit outside the block. They connect through plain valid/ready ports.

Top module: `hcp_top`

## Requirements
- R1: After reset, `consoleOff`, `busReq`, `rxPushValid`, `outValid` and `rxPopReady` are 0, `hostReady` is 1, and the configuration and address registers are zero.
- R2: A command is one opcode byte followed by four payload bytes, most significant byte first. Opcode 0x20 loads the payload as the bus address used by the next access.
- R3: Opcode 0x10 sets the configuration. Payload bit 0 drives `consoleOff` and grants the bus to the host. Payload bit 1 enables address auto-increment. Payload bits 31:2 have no effect.
- R4: Opcode 0x30 reads N words into the receive FIFO, where payload bits 23:0 hold N-1 and bits 31:24 are ignored. Words are pushed in the order they were read.
- R5: With auto-increment on, the address grows by 4 after every completed bus access. With it off, the address stays fixed.
- R6: With `consoleOff` set, opcode 0x40 makes exactly one bus write of the payload word at the current address. The request is held, with a stable address, until `busAck`.
- R7: With `consoleOff` clear, no bus request is raised. A read burst pushes 0x0000_0000 for each word, and a write command is discarded.
- R8: While `rxPushReady` is low, a read burst holds its pending word on `rxPushData` with `rxPushValid` high. It resumes without losing or repeating a word.
- R9: Opcode 0x50 (payload ignored) takes one word from the receive FIFO and sends it as four bytes on `outByte`, most significant first, each held until `outReady`. An empty FIFO yields four 0x00 bytes.
- R10: A byte received while an opcode is expected that is not 0x10, 0x20, 0x30, 0x40 or 0x50 is dropped, and the next byte is taken as an opcode.
- R11: `hostReady` is low while a command is being executed, so that bus activity and byte intake never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostByte | input | 8 | Incoming command byte |
| hostValid | input | 1 | `hostByte` is valid |
| hostReady | output | 1 | Block accepts a byte this cycle |
| outByte | output | 8 | Return byte towards the host |
| outValid | output | 1 | `outByte` is valid |
| outReady | input | 1 | Host takes the return byte |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data |
| busWrite | output | 1 | 1 = write, 0 = read |
| busReq | output | 1 | Bus request, held until acknowledge |
| busAck | input | 1 | Bus acknowledge, one cycle |
| rxPushData | output | 32 | Word for the receive FIFO |
| rxPushValid | output | 1 | Push request |
| rxPushReady | input | 1 | Receive FIFO has space |
| rxPopData | input | 32 | Head word of the receive FIFO |
| rxPopValid | input | 1 | Receive FIFO not empty |
| rxPopReady | output | 1 | Pop the head word |
| consoleOff | output | 1 | Console interface disabled, host owns the bus |

## Verification
The bench builds the block with its default parameters: a 24-bit length field and an address step of 4. This keeps read bursts of one to three words, and address steps across a small word-indexed bus memory, within direct reach.

The bench's bus model acknowledges one cycle after each request. Its receive FIFO model can be blocked on demand, so the stall, the burst ordering and the auto-increment sequence can all be seen in a few dozen cycles. The rarely used ranges of the length field are covered only through their ignored upper bits.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam logic [7:0] OP_CFG  = 8'h10;
  localparam logic [7:0] OP_ADDR = 8'h20;
  localparam logic [7:0] OP_READ = 8'h30;
  localparam logic [7:0] OP_WRITE = 8'h40;
  localparam logic [7:0] OP_FETCH = 8'h50;

  typedef enum logic [2:0] {
    S_OPC, S_PAY, S_EXEC, S_RDBUS, S_RDPUSH, S_WRBUS, S_POP, S_SEND
  } ctlState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadCfg;
    logic loadAddr;
    logic loadLen;
    logic decLen;
    logic incAddr;
    logic latchBus;
    logic latchZero;
    logic latchPop;
    logic shiftOut;
  } ctlStrobe_t;

  function automatic logic isKnownOp(input logic [7:0] op);
    return (op == OP_CFG) || (op == OP_ADDR) || (op == OP_READ) ||
           (op == OP_WRITE) || (op == OP_FETCH);
  endfunction
endpackage

// File: rtl/hcp_datapath.sv
module hcp_datapath
  import hcp_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int ADDR_STEP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  stb,
  input  logic [7:0]  hostByte,
  input  logic [31:0] busRdata,
  input  logic [31:0] rxPopData,
  input  logic        rxPopValid,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  output logic [31:0] rxPushData,
  output logic [7:0]  outByte,
  output logic        consoleOff,
  output logic        lenZero
);
  localparam logic [31:0] STEP = 32'(ADDR_STEP);

  logic [31:0] payload;
  logic [31:0] addrReg;
  logic [31:0] dataWord;
  logic [LEN_W-1:0] lenLeft;
  logic cfgInc;
  logic cfgOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payload  <= '0;
      addrReg  <= '0;
      dataWord <= '0;
      lenLeft  <= '0;
      cfgInc   <= 1'b0;
      cfgOff   <= 1'b0;
    end else begin
      if (stb.shiftIn)  payload <= {payload[23:0], hostByte};
      if (stb.loadCfg) begin
        cfgInc <= payload[1];
        cfgOff <= payload[0];
      end
      if (stb.loadAddr) addrReg <= payload;
      else if (stb.incAddr && cfgInc) addrReg <= addrReg + STEP;
      if (stb.loadLen) lenLeft <= payload[LEN_W-1:0];
      else if (stb.decLen) lenLeft <= lenLeft - 1'b1;
      if (stb.latchBus)       dataWord <= busRdata;
      else if (stb.latchZero) dataWord <= '0;
      else if (stb.latchPop)  dataWord <= rxPopValid ? rxPopData : '0;
      else if (stb.shiftOut)  dataWord <= {dataWord[23:0], 8'h00};
    end
  end

  assign busAddr    = addrReg;
  assign busWdata   = payload;
  assign rxPushData = dataWord;
  assign outByte    = dataWord[31:24];
  assign consoleOff = cfgOff;
  assign lenZero    = (lenLeft == '0);
endmodule

// File: rtl/hcp_control.sv
module hcp_control
  import hcp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] hostByte,
  input  logic       hostValid,
  input  logic       busAck,
  input  logic       rxPushReady,
  input  logic       outReady,
  input  logic       consoleOff,
  input  logic       lenZero,
  output logic       hostReady,
  output logic       busReq,
  output logic       busWrite,
  output logic       rxPushValid,
  output logic       rxPopReady,
  output logic       outValid,
  output ctlStrobe_t stb
);
  ctlState_t state, stateNext;
  logic [7:0] opReg;
  logic [1:0] byteCnt, byteCntNext;

  always_comb begin
    stateNext   = state;
    byteCntNext = byteCnt;
    stb         = '0;
    hostReady   = 1'b0;
    busReq      = 1'b0;
    busWrite    = 1'b0;
    rxPushValid = 1'b0;
    rxPopReady  = 1'b0;
    outValid    = 1'b0;
    unique case (state)
      S_OPC: begin
        hostReady = 1'b1;
        if (hostValid && isKnownOp(hostByte)) begin
          stateNext   = S_PAY;
          byteCntNext = '0;
        end
      end
      S_PAY: begin
        hostReady = 1'b1;
        if (hostValid) begin
          stb.shiftIn = 1'b1;
          byteCntNext = byteCnt + 1'b1;
          if (byteCnt == 2'd3) stateNext = S_EXEC;
        end
      end
      S_EXEC: begin
        stateNext = S_OPC;
        case (opReg)
          OP_CFG:   stb.loadCfg = 1'b1;
          OP_ADDR:  stb.loadAddr = 1'b1;
          OP_READ: begin
            stb.loadLen = 1'b1;
            stateNext   = S_RDBUS;
          end
          OP_WRITE: stateNext = S_WRBUS;
          OP_FETCH: stateNext = S_POP;
          default:  stateNext = S_OPC;
        endcase
      end
      S_RDBUS: begin
        if (consoleOff) begin
          busReq = 1'b1;
          if (busAck) begin
            stb.latchBus = 1'b1;
            stb.incAddr  = 1'b1;
            stateNext    = S_RDPUSH;
          end
        end else begin
          stb.latchZero = 1'b1;
          stateNext     = S_RDPUSH;
        end
      end
      S_RDPUSH: begin
        rxPushValid = 1'b1;
        if (rxPushReady) begin
          if (lenZero) stateNext = S_OPC;
          else begin
            stb.decLen = 1'b1;
            stateNext  = S_RDBUS;
          end
        end
      end
      S_WRBUS: begin
        if (consoleOff) begin
          busReq   = 1'b1;
          busWrite = 1'b1;
          if (busAck) begin
            stb.incAddr = 1'b1;
            stateNext   = S_OPC;
          end
        end else stateNext = S_OPC;
      end
      S_POP: begin
        rxPopReady   = 1'b1;
        stb.latchPop = 1'b1;
        byteCntNext  = '0;
        stateNext    = S_SEND;
      end
      S_SEND: begin
        outValid = 1'b1;
        if (outReady) begin
          stb.shiftOut = 1'b1;
          byteCntNext  = byteCnt + 1'b1;
          if (byteCnt == 2'd3) stateNext = S_OPC;
        end
      end
      default: stateNext = S_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_OPC;
      opReg   <= '0;
      byteCnt <= '0;
    end else begin
      state   <= stateNext;
      byteCnt <= byteCntNext;
      if (state == S_OPC && hostValid) opReg <= hostByte;
    end
  end
endmodule

// File: rtl/hcp_top.sv
module hcp_top
  import hcp_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int ADDR_STEP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  hostByte,
  input  logic        hostValid,
  output logic        hostReady,
  output logic [7:0]  outByte,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] busAddr,
  output logic [31:0] busWdata,
  input  logic [31:0] busRdata,
  output logic        busWrite,
  output logic        busReq,
  input  logic        busAck,
  output logic [31:0] rxPushData,
  output logic        rxPushValid,
  input  logic        rxPushReady,
  input  logic [31:0] rxPopData,
  input  logic        rxPopValid,
  output logic        rxPopReady,
  output logic        consoleOff
);
  ctlStrobe_t stb;
  logic lenZero;

  hcp_control u_ctl (
    .clk(clk), .rstN(rstN), .hostByte(hostByte), .hostValid(hostValid),
    .busAck(busAck), .rxPushReady(rxPushReady), .outReady(outReady),
    .consoleOff(consoleOff), .lenZero(lenZero), .hostReady(hostReady),
    .busReq(busReq), .busWrite(busWrite), .rxPushValid(rxPushValid),
    .rxPopReady(rxPopReady), .outValid(outValid), .stb(stb)
  );

  hcp_datapath #(.LEN_W(LEN_W), .ADDR_STEP(ADDR_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostByte(hostByte),
    .busRdata(busRdata), .rxPopData(rxPopData), .rxPopValid(rxPopValid),
    .busAddr(busAddr), .busWdata(busWdata), .rxPushData(rxPushData),
    .outByte(outByte), .consoleOff(consoleOff), .lenZero(lenZero)
  );
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostReady,
  input logic        busReq,
  input logic        busAck,
  input logic        busWrite,
  input logic [31:0] busAddr,
  input logic        consoleOff,
  input logic        rxPushValid,
  input logic        rxPushReady,
  input logic [31:0] rxPushData,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outByte
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWrite)); // R6
  AST_NO_BUS_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    !consoleOff |-> !busReq); // R7
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rxPushValid && !consoleOff |-> rxPushData == 32'h0); // R7
  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rxPushValid && !rxPushReady |=> rxPushValid && $stable(rxPushData)); // R8
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte)); // R9
  AST_INTAKE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !busReq && !rxPushValid && !outValid); // R11
endmodule

bind hcp_top hcp_checker u_chk (.*);

// File: tb/tb_hcp_top.sv
module tb_hcp_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hostByte = '0;
  logic hostValid = 1'b0;
  logic hostReady;
  logic [7:0] outByte;
  logic outValid;
  logic outReady = 1'b1;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;
  logic busWrite, busReq;
  logic busAck = 1'b0;
  logic [31:0] rxPushData;
  logic rxPushValid;
  logic rxPushReady = 1'b0;
  logic [31:0] rxPopData = '0;
  logic rxPopValid = 1'b0;
  logic rxPopReady;
  logic consoleOff;

  int checks = 0;
  int fails = 0;
  int busRdCount = 0;
  int busWrCount = 0;
  logic pushBlock = 1'b0;
  logic [31:0] mem [16];
  logic [31:0] rxQ[$];
  logic [7:0] outQ[$];
  logic [31:0] wrAddrQ[$];
  logic [31:0] wrDataQ[$];

  always #2 clk = ~clk;

  hcp_top dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // environment: bus slave, receive FIFO, byte sink
  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA500_0000 + 32'(i) * 32'h111;
    forever begin
      @(negedge clk);
      if (busReq && !busAck) begin
        busAck = 1'b1;
        if (busWrite) begin
          busWrCount++;
          wrAddrQ.push_back(busAddr);
          wrDataQ.push_back(busWdata);
        end else begin
          busRdCount++;
          busRdata = mem[busAddr[5:2]];
        end
      end else busAck = 1'b0;
      rxPushReady = !pushBlock;
      if (rxPushValid && rxPushReady) rxQ.push_back(rxPushData);
      rxPopValid = (rxQ.size() > 0);
      rxPopData  = rxPopValid ? rxQ[0] : 32'h0;
      if (rxPopReady && rxPopValid) void'(rxQ.pop_front());
      if (outValid && outReady) outQ.push_back(outByte);
    end
  end

  task automatic sendByte(input logic [7:0] b);
    int t = 0;
    @(negedge clk);
    while (!hostReady && t < 1000) begin @(negedge clk); t++; end
    hostByte  = b;
    hostValid = 1'b1;
    @(negedge clk);
    hostValid = 1'b0;
  endtask

  task automatic waitIdle();
    int t = 0;
    while (!hostReady && t < 1000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] op, input logic [31:0] w);
    sendByte(op);
    for (int i = 3; i >= 0; i--) sendByte(w[i*8 +: 8]);
    waitIdle();
  endtask

  task automatic testReset();
    @(negedge clk);
    check(consoleOff == 0 && busReq == 0 && rxPushValid == 0 && outValid == 0
          && rxPopReady == 0, "R1 idle outputs", {27'b0, consoleOff, busReq,
          rxPushValid, outValid, rxPopReady}, 32'h0);
    check(hostReady == 1, "R1 hostReady", 32'(hostReady), 32'h1);
  endtask

  task automatic testConfig();
    sendCmd(8'h10, 32'hFFFF_FFFC);
    check(consoleOff == 0, "R3 upper bits ignored", 32'(consoleOff), 32'h0);
    sendCmd(8'h10, 32'h0000_0003);
    check(consoleOff == 1, "R3 bit0 sets consoleOff", 32'(consoleOff), 32'h1);
  endtask

  task automatic testWriteInc();
    int base = wrAddrQ.size();
    sendCmd(8'h20, 32'h0000_0010);
    sendCmd(8'h40, 32'hCAFE_BABE);
    sendCmd(8'h40, 32'h1234_5678);
    check(wrAddrQ.size() == base + 2, "R6 two writes", 32'(wrAddrQ.size() - base), 32'h2);
    if (wrAddrQ.size() == base + 2) begin
      check(wrAddrQ[base] == 32'h10 && wrDataQ[base] == 32'hCAFE_BABE,
            "R2 R6 first write", wrAddrQ[base], 32'h10);
      check(wrAddrQ[base+1] == 32'h14 && wrDataQ[base+1] == 32'h1234_5678,
            "R5 incremented write", wrAddrQ[base+1], 32'h14);
    end
  endtask

  task automatic testWriteFixed();
    int base = wrAddrQ.size();
    sendCmd(8'h10, 32'h0000_0001);
    sendCmd(8'h20, 32'h0000_0030);
    sendCmd(8'h40, 32'h1111_1111);
    sendCmd(8'h40, 32'h2222_2222);
    check(wrAddrQ.size() == base + 2, "R5 fixed count", 32'(wrAddrQ.size() - base), 32'h2);
    if (wrAddrQ.size() == base + 2)
      check(wrAddrQ[base] == 32'h30 && wrAddrQ[base+1] == 32'h30 &&
            wrDataQ[base+1] == 32'h2222_2222, "R5 address fixed", wrAddrQ[base+1], 32'h30);
  endtask

  task automatic testReadBurst();
    int rd0 = busRdCount;
    rxQ.delete();
    sendCmd(8'h10, 32'h0000_0003);
    sendCmd(8'h20, 32'h0000_0020);
    sendCmd(8'h30, 32'hFF00_0002);
    check(rxQ.size() == 3, "R4 burst length", 32'(rxQ.size()), 32'h3);
    check(busRdCount - rd0 == 3, "R4 bus reads", 32'(busRdCount - rd0), 32'h3);
    for (int i = 0; i < 3; i++)
      if (i < rxQ.size())
        check(rxQ[i] == mem[8+i], "R4 R5 burst word", rxQ[i], mem[8+i]);
  endtask

  task automatic testFetch();
    logic [31:0] exp = (rxQ.size() > 0) ? rxQ[0] : 32'h0;
    outQ.delete();
    sendCmd(8'h50, 32'h0);
    repeat (4) @(negedge clk);
    check(outQ.size() == 4, "R9 byte count", 32'(outQ.size()), 32'h4);
    if (outQ.size() == 4)
      check({outQ[0], outQ[1], outQ[2], outQ[3]} == exp, "R9 byte order",
            {outQ[0], outQ[1], outQ[2], outQ[3]}, exp);
    check(rxQ.size() == 2, "R9 one word popped", 32'(rxQ.size()), 32'h2);
  endtask

  task automatic testFetchEmpty();
    rxQ.delete();
    outQ.delete();
    sendCmd(8'h50, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    check(outQ.size() == 4, "R9 empty byte count", 32'(outQ.size()), 32'h4);
    if (outQ.size() == 4)
      check({outQ[0], outQ[1], outQ[2], outQ[3]} == 32'h0, "R9 empty zeros",
            {outQ[0], outQ[1], outQ[2], outQ[3]}, 32'h0);
  endtask

  task automatic testStall();
    int t = 0;
    rxQ.delete();
    pushBlock = 1'b1;
    sendCmd(8'h20, 32'h0000_0004);
    sendByte(8'h30);
    for (int i = 3; i >= 0; i--) sendByte(i == 0 ? 8'h01 : 8'h00);
    while (!rxPushValid && t < 100) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
    check(rxPushValid == 1 && rxQ.size() == 0, "R8 stalled", 32'(rxQ.size()), 32'h0);
    check(rxPushData == mem[1], "R8 pending word held", rxPushData, mem[1]);
    check(hostReady == 0, "R11 intake closed", 32'(hostReady), 32'h0);
    pushBlock = 1'b0;
    waitIdle();
    check(rxQ.size() == 2, "R8 resumed count", 32'(rxQ.size()), 32'h2);
    if (rxQ.size() == 2)
      check(rxQ[0] == mem[1] && rxQ[1] == mem[2], "R8 resumed order", rxQ[1], mem[2]);
  endtask

  task automatic testNotOwned();
    int rd0 = busRdCount;
    int wr0 = busWrCount;
    rxQ.delete();
    sendCmd(8'h10, 32'hFFFF_FFFE);
    check(consoleOff == 0, "R7 consoleOff clear", 32'(consoleOff), 32'h0);
    sendCmd(8'h30, 32'h0000_0001);
    check(rxQ.size() == 2, "R7 dummy count", 32'(rxQ.size()), 32'h2);
    if (rxQ.size() == 2)
      check(rxQ[0] == 32'h0 && rxQ[1] == 32'h0, "R7 dummy zero", rxQ[1], 32'h0);
    sendCmd(8'h40, 32'hBAD0_BAD0);
    check(busRdCount == rd0 && busWrCount == wr0, "R7 no bus traffic",
          32'(busRdCount + busWrCount - rd0 - wr0), 32'h0);
  endtask

  task automatic testUnknown();
    int base = wrAddrQ.size();
    sendCmd(8'h10, 32'h0000_0003);
    sendByte(8'h77);
    sendCmd(8'h20, 32'h0000_0008);
    sendCmd(8'h40, 32'hDEAD_0001);
    check(wrAddrQ.size() == base + 1, "R10 write after junk", 32'(wrAddrQ.size() - base), 32'h1);
    if (wrAddrQ.size() == base + 1)
      check(wrAddrQ[base] == 32'h8 && wrDataQ[base] == 32'hDEAD_0001,
            "R10 resync address", wrAddrQ[base], 32'h8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testConfig();
    testWriteInc();
    testWriteFixed();
    testReadBurst();
    testFetch();
    testFetchEmpty();
    sendCmd(8'h10, 32'h0000_0003);
    testStall();
    testNotOwned();
    testUnknown();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule